// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block sits next to an SPI master and drives an external successive-approximation converter. Software hands it a channel number, a range code and a single-ended flag. The block packs these fields into the 8-bit command that the SPI master sends, and it asks the master to start a frame. It then holds off any further command until a conversion has been started for that command.

A conversion request may arrive while the frame is still shifting or while the acquisition wait is still running. The request is kept and the start pulse goes out on its own once the converter has had time to settle. That wait is counted from the end of the frame, and its length depends on the SPI clock rate. A busy flag is raised from the request and stays up for the whole conversion time.

A frame returns the result of the conversion before the one just commanded. The block therefore tags each captured sample with the channel of the conversion that was last started before that frame.

Top module: `adc_conv_sequencer`

## Requirements
- R1: On an accepted command, `cmd_byte` becomes {single, chan[0], chan[2:1], range[1:0], 2'b00}. For example, channel 3, range code 2, single-ended gives D8h. Range codes are 0 = ±5 V, 1 = ±10 V, 2 = 0..+5 V and 3 = 0..+10 V.
- R2: A `cmd_wr` sampled while `locked` is low is accepted. In the next cycle `cmd_launch` is high for exactly one cycle and `locked` is high.
- R3: A `cmd_wr` sampled while `locked` is high starts no frame, leaves `cmd_byte` unchanged and sets `cmd_err`. A lone `err_clr` clears `cmd_err`. When a blocked write and `err_clr` fall in the same cycle, the flag stays set.
- R4: `locked` stays high from acceptance until the end of the conversion-start pulse for that command, and drops in the first cycle after the pulse.
- R5: Once `spi_busy` has fallen, no start pulse appears until the acquisition wait has run: 0 cycles for `spi_rate` 0 (2 MHz), ACQ4_CYC (1.5 µs) for code 1 (4 MHz), and ACQ8_CYC (2.75 µs) for codes 2 and 3 (8 MHz). Counting from the cycle in which `spi_busy` is first seen low, a pending request starts exactly N+2 cycles later.
- R6: A `conv_req` while `adc_busy` is low raises `adc_busy` in the next cycle. If the converter is not ready, the request is held and issued when it becomes ready. If it is ready, `conv_start` rises in the next cycle.
- R7: `conv_start` is one pulse of exactly PULSE_CYC cycles (at least 100 ns). It is never high while `spi_busy` is high.
- R8: `adc_busy` stays high for exactly CONV_CYC cycles (5 µs), counted from the first cycle of the start pulse. A `conv_req` made while `adc_busy` is high is ignored.
- R9: A `rx_valid` strobe captures `rx_data[15:4]` into `sample` in the next cycle. `sample_chan` then holds the channel of the most recently started conversion. `sample_valid` pulses only once a conversion has been started since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_chan | input | 3 | Channel number |
| cmd_range | input | 2 | Input range code |
| cmd_single | input | 1 | Single-ended select |
| spi_rate | input | 2 | SPI clock rate code |
| spi_busy | input | 1 | SPI frame in progress |
| conv_req | input | 1 | Conversion-start request (write 1) |
| err_clr | input | 1 | Clear the blocked-command flag (write 1) |
| rx_valid | input | 1 | Received 16-bit frame strobe |
| rx_data | input | 16 | Received frame, result in bits 15:4 |
| cmd_byte | output | 8 | Command byte for the SPI master |
| cmd_launch | output | 1 | One-cycle frame start request |
| locked | output | 1 | Command interlock active |
| cmd_err | output | 1 | Sticky blocked-command flag |
| conv_start | output | 1 | Conversion-start pulse to converter |
| adc_busy | output | 1 | Conversion in progress or pending |
| sample | output | 12 | Captured conversion result |
| sample_chan | output | 3 | Channel that produced `sample` |
| sample_valid | output | 1 | One-cycle sample strobe |

## Verification
Two coincidences are provoked on purpose. The first is a start request landing while the frame is still active, or partway through the acquisition wait. The bench picks at random whether the request comes early or at some offset after the frame ends, and checks that the pulse appears at the later of N+2 and offset+1 cycles. The second is a blocked command write arriving in the same cycle as an error clear; the bench judges that the error flag survives. A request during the busy window after the pulse is also shown to leave no second pulse and no extension of busy.

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer #(
  parameter int CONV_CYC  = 625,
  parameter int ACQ4_CYC  = 188,
  parameter int ACQ8_CYC  = 344,
  parameter int PULSE_CYC = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [2:0]  cmd_chan,
  input  logic [1:0]  cmd_range,
  input  logic        cmd_single,
  input  logic [1:0]  spi_rate,
  input  logic        spi_busy,
  input  logic        conv_req,
  input  logic        err_clr,
  input  logic        rx_valid,
  input  logic [15:0] rx_data,
  output logic [7:0]  cmd_byte,
  output logic        cmd_launch,
  output logic        locked,
  output logic        cmd_err,
  output logic        conv_start,
  output logic        adc_busy,
  output logic [11:0] sample,
  output logic [2:0]  sample_chan,
  output logic        sample_valid
);
  localparam int ACQ_MAX = (ACQ8_CYC > ACQ4_CYC) ? ACQ8_CYC : ACQ4_CYC;
  localparam int AW = $clog2(ACQ_MAX + 1);
  localparam int CW = $clog2(CONV_CYC + 1);
  localparam int PW = $clog2(PULSE_CYC + 1);

  logic          lock_q, frame_pend, busy_d, pend_q, have_conv;
  logic [AW-1:0] acq_cnt;
  logic [CW-1:0] conv_cnt;
  logic [PW-1:0] pulse_cnt;
  logic [2:0]    conv_chan;
  logic [AW-1:0] acq_len;

  wire accept  = cmd_wr & ~locked;
  wire frame_end = busy_d & ~spi_busy;
  wire ready   = ~frame_pend & ~spi_busy & (acq_cnt == '0);
  wire new_req = conv_req & ~adc_busy;
  wire issue   = ready & (pend_q | new_req);

  assign conv_start = (pulse_cnt != '0);
  assign adc_busy   = pend_q | (conv_cnt != '0);
  assign locked     = lock_q | pend_q | conv_start;

  always_comb begin
    case (spi_rate)
      2'd0:    acq_len = '0;
      2'd1:    acq_len = AW'(ACQ4_CYC);
      default: acq_len = AW'(ACQ8_CYC);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_byte <= '0; cmd_launch <= 1'b0; lock_q <= 1'b0; cmd_err <= 1'b0;
      frame_pend <= 1'b0; busy_d <= 1'b0; acq_cnt <= '0; pend_q <= 1'b0;
      pulse_cnt <= '0; conv_cnt <= '0; have_conv <= 1'b0; conv_chan <= '0;
      sample <= '0; sample_chan <= '0; sample_valid <= 1'b0;
    end else begin
      cmd_launch <= accept;
      busy_d     <= spi_busy;
      if (accept) cmd_byte <= {cmd_single, cmd_chan[0], cmd_chan[2:1], cmd_range, 2'b00};

      if (pulse_cnt == PW'(1)) lock_q <= 1'b0;
      else if (accept)         lock_q <= 1'b1;

      if (cmd_wr && locked) cmd_err <= 1'b1;
      else if (err_clr)     cmd_err <= 1'b0;

      if (accept)         frame_pend <= 1'b1;
      else if (frame_end) frame_pend <= 1'b0;

      if (frame_end)          acq_cnt <= acq_len;
      else if (acq_cnt != '0) acq_cnt <= acq_cnt - 1'b1;

      if (issue)        pend_q <= 1'b0;
      else if (new_req) pend_q <= 1'b1;

      if (issue) begin
        pulse_cnt <= PW'(PULSE_CYC);
        conv_cnt  <= CW'(CONV_CYC);
        have_conv <= 1'b1;
        conv_chan <= {cmd_byte[5:4], cmd_byte[6]};
      end else begin
        if (pulse_cnt != '0) pulse_cnt <= pulse_cnt - 1'b1;
        if (conv_cnt != '0)  conv_cnt  <= conv_cnt - 1'b1;
      end

      sample_valid <= rx_valid & have_conv;
      if (rx_valid) begin
        sample      <= rx_data[15:4];
        sample_chan <= conv_chan;
      end
    end
  end

  assert_launch_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_launch |=> !cmd_launch);
  assert_launch_locks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_launch |-> locked);
  assert_blocked_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && locked) |=> cmd_err);
  assert_cmd_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && $past(lock_q)) |-> $stable(cmd_byte));
  assert_busy_on_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && !adc_busy) |=> adc_busy);
  assert_no_start_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !spi_busy);
  assert_start_after_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_start) |-> !$past(spi_busy));
  assert_busy_covers_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> adc_busy);
endmodule

// File: tb/adc_conv_sequencer_test.sv
module adc_conv_sequencer_test;
  localparam int CONV  = 625;
  localparam int ACQ4  = 188;
  localparam int ACQ8  = 344;
  localparam int PULSE = 13;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_wr = 0, cmd_single = 0, spi_busy = 0, conv_req = 0, err_clr = 0, rx_valid = 0;
  logic [2:0] cmd_chan = 0;
  logic [1:0] cmd_range = 0, spi_rate = 0;
  logic [15:0] rx_data = 0;
  logic [7:0] cmd_byte;
  logic cmd_launch, locked, cmd_err, conv_start, adc_busy, sample_valid;
  logic [11:0] sample;
  logic [2:0] sample_chan;

  int checks = 0, fails = 0;
  bit have_conv = 0;
  logic [2:0] prev_chan = 0;

  always #4 clk = ~clk;

  adc_conv_sequencer #(.CONV_CYC(CONV), .ACQ4_CYC(ACQ4), .ACQ8_CYC(ACQ8), .PULSE_CYC(PULSE)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_chan(cmd_chan), .cmd_range(cmd_range),
    .cmd_single(cmd_single), .spi_rate(spi_rate), .spi_busy(spi_busy), .conv_req(conv_req),
    .err_clr(err_clr), .rx_valid(rx_valid), .rx_data(rx_data), .cmd_byte(cmd_byte),
    .cmd_launch(cmd_launch), .locked(locked), .cmd_err(cmd_err), .conv_start(conv_start),
    .adc_busy(adc_busy), .sample(sample), .sample_chan(sample_chan), .sample_valid(sample_valid));

  function automatic logic [7:0] enc(logic [2:0] ch, logic [1:0] rg, logic se);
    return {se, ch[0], ch[2:1], rg, 2'b00};
  endfunction

  function automatic int acq_of(logic [1:0] rate);
    return (rate == 2'd0) ? 0 : (rate == 2'd1) ? ACQ4 : ACQ8;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic txn(logic [2:0] ch, logic [1:0] rg, logic se, logic [1:0] rate, bit early, int flen, int k);
    logic [7:0] exp_b;
    logic [15:0] rx;
    int n, cnt, w, b;
    bit lockchk;
    exp_b = enc(ch, rg, se);
    n = acq_of(rate);
    @(negedge clk);
    spi_rate = rate; cmd_chan = ch; cmd_range = rg; cmd_single = se; cmd_wr = 1;
    @(negedge clk); cmd_wr = 0;
    check(cmd_launch == 1'b1, "R2 launch", int'(cmd_launch), 1);
    check(cmd_byte == exp_b, "R1 encode", int'(cmd_byte), int'(exp_b));
    check(locked == 1'b1, "R2 lock", int'(locked), 1);
    @(negedge clk);
    check(cmd_launch == 1'b0, "R2 single", int'(cmd_launch), 0);
    spi_busy = 1;
    repeat (3) @(negedge clk);
    cmd_chan = ch ^ 3'd1; cmd_range = ~rg; cmd_wr = 1;
    @(negedge clk); cmd_wr = 0;
    check(cmd_launch == 1'b0, "R3 no launch", int'(cmd_launch), 0);
    check(cmd_byte == exp_b, "R3 byte held", int'(cmd_byte), int'(exp_b));
    check(cmd_err == 1'b1, "R3 err set", int'(cmd_err), 1);
    cmd_wr = 1; err_clr = 1;
    @(negedge clk); cmd_wr = 0; err_clr = 0;
    check(cmd_err == 1'b1, "R3 set wins", int'(cmd_err), 1);
    err_clr = 1;
    @(negedge clk); err_clr = 0;
    check(cmd_err == 1'b0, "R3 clear", int'(cmd_err), 0);
    if (early) begin
      conv_req = 1;
      @(negedge clk); conv_req = 0;
      check(adc_busy == 1'b1, "R6 busy on req", int'(adc_busy), 1);
      check(conv_start == 1'b0, "R6 held in frame", int'(conv_start), 0);
    end
    repeat (flen) @(negedge clk);
    check(conv_start == 1'b0, "R7 no start in frame", int'(conv_start), 0);
    rx = 16'($urandom);
    rx_valid = 1; rx_data = rx;
    @(negedge clk); rx_valid = 0;
    check(sample_valid == have_conv, "R9 valid", int'(sample_valid), int'(have_conv));
    if (have_conv) begin
      check(sample == rx[15:4], "R9 data", int'(sample), int'(rx[15:4]));
      check(sample_chan == prev_chan, "R9 prev channel", int'(sample_chan), int'(prev_chan));
    end
    spi_busy = 0;
    cnt = 0;
    if (!early && k == 0) conv_req = 1;
    while (!conv_start && cnt < 2000) begin
      @(negedge clk); conv_req = 0; cnt++;
      if (!early && cnt == k) conv_req = 1;
    end
    conv_req = 0;
    if (early) check(cnt == n + 2, "R5 acq wait", cnt, n + 2);
    else begin
      w = (k + 1 > n + 2) ? k + 1 : n + 2;
      check(cnt == w, "R6 late req", cnt, w);
    end
    check(locked == 1'b1, "R4 locked in pulse", int'(locked), 1);
    w = 1; b = 1; lockchk = 0;
    while (adc_busy && b < 3000) begin
      @(negedge clk); conv_req = 0;
      if (conv_start) w++;
      else if (!lockchk) begin
        check(locked == 1'b0, "R4 released", int'(locked), 0);
        lockchk = 1; conv_req = 1;
      end
      if (adc_busy) b++;
    end
    conv_req = 0;
    check(w == PULSE, "R7 pulse width", w, PULSE);
    check(b == CONV, "R8 busy length", b, CONV);
    @(negedge clk);
    check(conv_start == 1'b0 && adc_busy == 1'b0, "R8 req ignored", int'({conv_start, adc_busy}), 0);
    have_conv = 1; prev_chan = ch;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(cmd_byte == 8'h00 && !cmd_launch && !locked && !cmd_err, "R2 reset", int'(cmd_byte), 0);
    check(!conv_start && !adc_busy && !sample_valid, "R8 reset", int'({conv_start, adc_busy}), 0);
    check(enc(3'd3, 2'd2, 1'b1) == 8'hD8, "R1 example", int'(enc(3'd3, 2'd2, 1'b1)), 8'hD8);
    txn(3'd3, 2'd2, 1'b1, 2'd0, 1'b1, 20, 0);
    txn(3'd7, 2'd3, 1'b0, 2'd2, 1'b0, 25, 1);
    txn(3'd0, 2'd0, 1'b1, 2'd1, 1'b0, 30, ACQ4 + 6);
    for (int i = 0; i < 24; i++) begin
      logic [1:0] r;
      r = 2'($urandom);
      txn(3'($urandom), 2'($urandom), 1'($urandom), r, 1'($urandom),
          20 + int'($urandom % 40), int'($urandom % (acq_of(r) + 6)));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule